// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the arithmetic and logic stage of a simple three-operand integer pipeline. Each cycle it takes two 32-bit source operands, a 5-bit constant shift amount and a 5-bit operation code. It returns a 32-bit result without delay. It handles wrapping and trapping add/subtract, bitwise logic, signed and unsigned set-less-than, upper-immediate placement, and shifts by a constant or by a register amount. Operand fetch, immediate extension and instruction decode happen upstream. The core therefore supplies an already-extended immediate on `src_b` whenever an immediate form is executed; an add-immediate, for example, arrives as the trapping add code.

Only the trapping add and trapping subtract can report two's-complement overflow. Every other operation wraps or saturates silently. While a trap is active, the destination write enable is withheld. When the issue strobe `op_valid` is high on a rising clock edge, a registered exception flag captures the trap so that a downstream handler can see it.

The block never stalls. It has no ready output and applies no back-pressure: every cycle with `op_valid` high counts as one issued operation, and the upstream stage may hold or change the inputs freely.

Top module: `int_alu`

## Requirements
- R1: Code 0 (trapping add) returns `src_a + src_b` modulo 2^32, and code 2 (trapping subtract) returns `src_a - src_b` modulo 2^32. For either code, `ovf_trap` is 1 exactly when the true signed result falls outside -2^31..2^31-1.
- R2: Code 1 (wrapping add) and code 3 (wrapping subtract) return the same sums as R1 and keep `ovf_trap` at 0. Every code other than 0 and 2 keeps `ovf_trap` at 0.
- R3: `wr_en` equals `op_valid` with the trap masked out, so an overflowing trapping add or subtract never enables the destination write.
- R4: Codes 4, 5, 6 and 7 return, in that order, bitwise AND, OR, XOR and NOR (the inverse of OR) of the operands.
- R5: Code 8 (signed) and code 9 (unsigned) return 1 in bit 0 when `src_a < src_b`, and 0 otherwise, with bits 31..1 always clear. An all-ones `src_a` against 1 gives 1 for code 8 and 0 for code 9.
- R6: Code 10 places `src_b[15:0]` in result bits 31..16 and clears bits 15..0.
- R7: Codes 11, 12 and 13 shift `src_a` by `shamt` (0..31): left with zero fill, right with zero fill, and right with copies of bit 31 filling the vacated bits, respectively.
- R8: Codes 14, 15 and 16 perform the same three shifts of `src_a`, but take the amount from `src_b[4:0]` only and ignore `src_b[31:5]`.
- R9: `exc_flag` is 0 during and after reset. On each rising edge with `op_valid` high, it loads the current `ovf_trap`. With `op_valid` low, it holds its value.
- R10: Codes 17 to 31 are unassigned. They return a zero result with `ovf_trap` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the exception flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe for the current operation |
| op_sel | input | 5 | Operation code (see requirements) |
| src_a | input | 32 | First operand; value to shift |
| src_b | input | 32 | Second operand; variable shift amount in low 5 bits |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Combinational result |
| ovf_trap | output | 1 | Signed overflow on a trapping add/subtract |
| wr_en | output | 1 | Destination write enable |
| exc_flag | output | 1 | Registered overflow captured on issue |

## Verification
The bench builds the block with its default 32-bit data width, so the shift amount is 5 bits and the upper-immediate field is 16 bits. That choice brings the boundary operands into play: 0x7FFFFFFF, 0x80000000 and all ones, which decide overflow, sign fill and the signed-versus-unsigned compare split. It also lets a variable shift operand carry set bits above bit 4, which shows that only the low field is used. The random mix covers every assigned code and several unassigned ones, with the issue strobe toggled so that both capture and hold of the exception flag occur.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_LUI  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  // Subtract by inverting the second operand and injecting a carry.
  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];

  // Same-sign inputs with a sign change on the output.
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

  // Compare results, meaningful while sub is set.
  assign lt_s  = sum[W-1] ^ ovf;
  assign lt_u  = ~wide[W];
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  input  int_alu_pkg::logic_fn_e  fn,
  output logic [W-1:0]            res
);
  import int_alu_pkg::*;

  always_comb begin
    unique case (fn)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  res
);
  logic         fill;
  logic [W-1:0] stage [SW+1];

  assign fill     = arith & val[W-1];
  assign stage[0] = val;

  // Log-depth barrel: stage i moves the data by 2**i when amt[i] is set.
  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int SH = 1 << i;
    logic [W-1:0] moved;
    always_comb begin
      if (left) moved = {stage[i][W-1-SH:0], {SH{1'b0}}};
      else      moved = {{SH{fill}}, stage[i][W-1:SH]};
    end
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign res = stage[SW];
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W     = 32,
  parameter int SW    = $clog2(W),
  parameter int IMM_W = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_sel,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  result,
  output logic          ovf_trap,
  output logic          wr_en,
  output logic          exc_flag
);
  import int_alu_pkg::*;

  localparam int LOW_W = W - IMM_W;

  alu_op_e      op;
  logic         do_sub;
  logic [W-1:0] as_sum;
  logic         as_ovf, as_lts, as_ltu;
  logic_fn_e    lg_fn;
  logic [W-1:0] lg_res;
  logic [SW-1:0] sh_amt;
  logic         sh_left, sh_arith;
  logic [W-1:0] sh_res;
  logic         trapping;

  assign op = alu_op_e'(op_sel);

  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) ||
                  (op == OP_SLT) || (op == OP_SLTU);

  int_alu_addsub #(.W(W)) u_addsub (
    .a    (src_a),
    .b    (src_b),
    .sub  (do_sub),
    .sum  (as_sum),
    .ovf  (as_ovf),
    .lt_s (as_lts),
    .lt_u (as_ltu)
  );

  always_comb begin
    case (op)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      OP_NOR:  lg_fn = LG_NOR;
      default: lg_fn = LG_AND;
    endcase
  end

  int_alu_logic #(.W(W)) u_logic (
    .a   (src_a),
    .b   (src_b),
    .fn  (lg_fn),
    .res (lg_res)
  );

  // Variable forms take only the low field of the second operand.
  assign sh_amt   = ((op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV))
                    ? src_b[SW-1:0] : shamt;
  assign sh_left  = (op == OP_SLL) || (op == OP_SLLV);
  assign sh_arith = (op == OP_SRA) || (op == OP_SRAV);

  int_alu_shift #(.W(W), .SW(SW)) u_shift (
    .val   (src_a),
    .amt   (sh_amt),
    .left  (sh_left),
    .arith (sh_arith),
    .res   (sh_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:
        result = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:
        result = lg_res;
      OP_SLT:
        result = {{(W-1){1'b0}}, as_lts};
      OP_SLTU:
        result = {{(W-1){1'b0}}, as_ltu};
      OP_LUI:
        result = {src_b[IMM_W-1:0], {LOW_W{1'b0}}};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV:
        result = sh_res;
      default:
        result = '0;
    endcase
  end

  assign trapping = (op == OP_ADD) || (op == OP_SUB);
  assign ovf_trap = trapping & as_ovf;
  assign wr_en    = op_valid & ~ovf_trap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        exc_flag <= 1'b0;
    else if (op_valid) exc_flag <= ovf_trap;
  end
endmodule

// File: rtl/int_alu_checks.sv
module int_alu_checks #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [4:0]    op_sel,
  input logic [W-1:0]  src_a,
  input logic [W-1:0]  src_b,
  input logic [SW-1:0] shamt,
  input logic [W-1:0]  result,
  input logic          ovf_trap,
  input logic          wr_en,
  input logic          exc_flag
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (op_sel == 5'd0 || op_sel == 5'd2));

  p_write_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> !wr_en);

  p_compare_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd8 || op_sel == 5'd9) |-> (result[W-1:1] == '0));

  p_upper_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd10) |-> (result[W/2-1:0] == '0));

  p_unassigned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 5'd16) |-> (result == '0 && !ovf_trap));

  p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (exc_flag == $past(ovf_trap)));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(exc_flag));
endmodule

bind int_alu int_alu_checks #(.W(W), .SW(SW)) u_int_alu_checks (.*);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf_trap, wr_en, exc_flag;

  int checks = 0;
  int failures = 0;
  logic exp_flag = 1'b0;

  always #2 clk = ~clk;

  int_alu u_int_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .shamt(shamt), .result(result),
    .ovf_trap(ovf_trap), .wr_en(wr_en), .exc_flag(exc_flag)
  );

  function automatic logic [31:0] model_res(input logic [4:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] sh);
    logic [4:0] va;
    va = b[4:0];
    case (op)
      5'd0, 5'd1:  return a + b;
      5'd2, 5'd3:  return a - b;
      5'd4:  return a & b;
      5'd5:  return a | b;
      5'd6:  return a ^ b;
      5'd7:  return ~(a | b);
      5'd8:  return {31'b0, ($signed(a) < $signed(b))};
      5'd9:  return {31'b0, (a < b)};
      5'd10: return {b[15:0], 16'h0000};
      5'd11: return a << sh;
      5'd12: return a >> sh;
      5'd13: return $signed(a) >>> sh;
      5'd14: return a << va;
      5'd15: return a >> va;
      5'd16: return $signed(a) >>> va;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic model_trap(input logic [4:0] op, input logic [31:0] a,
                                      input logic [31:0] b);
    longint sa, sb, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (op == 5'd0)      r = sa + sb;
    else if (op == 5'd2) r = sa - sb;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic string req_tag(input logic [4:0] op);
    case (op)
      5'd0, 5'd2: return "R1";
      5'd1, 5'd3: return "R2";
      5'd4, 5'd5, 5'd6, 5'd7: return "R4";
      5'd8, 5'd9: return "R5";
      5'd10: return "R6";
      5'd11, 5'd12, 5'd13: return "R7";
      5'd14, 5'd15, 5'd16: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic v);
    logic t;
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; shamt = sh; op_valid = v;
    #1;
    t = model_trap(op, a, b);
    chk(req_tag(op), "result", result, model_res(op, a, b, sh));
    chk(t ? "R1" : "R2", "ovf_trap", {31'b0, ovf_trap}, {31'b0, t});
    chk("R3", "wr_en", {31'b0, wr_en}, {31'b0, v & ~t});
    @(posedge clk);
    #1;
    if (v) exp_flag = t;
    chk("R9", "exc_flag", {31'b0, exc_flag}, {31'b0, exp_flag});
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "exc_flag in reset", {31'b0, exc_flag}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 signed overflow on add and subtract; R3 write blocked.
    apply(5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 1'b1);
    apply(5'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, 1'b1);
    // R9 hold while idle: flag stays 1.
    apply(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 1'b0);
    // R2 wrapping forms never trap.
    apply(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 1'b1);
    apply(5'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, 1'b1);
    apply(5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 1'b1);
    // R5 all ones against 1.
    apply(5'd8, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 1'b1);
    apply(5'd9, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 1'b1);
    apply(5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 1'b1);
    // R4 NOR.
    apply(5'd7, 32'hF0F0_0000, 32'h0F00_00FF, 5'd0, 1'b1);
    // R6 upper immediate.
    apply(5'd10, 32'h1234_5678, 32'hABCD_BEEF, 5'd0, 1'b1);
    // R7 sign fill versus zero fill.
    apply(5'd13, 32'h8000_0000, 32'h0, 5'd31, 1'b1);
    apply(5'd12, 32'h8000_0000, 32'h0, 5'd31, 1'b1);
    apply(5'd11, 32'h0000_0001, 32'h0, 5'd31, 1'b1);
    apply(5'd13, 32'h8000_0001, 32'h0, 5'd0, 1'b1);
    // R8 upper bits of the amount operand ignored.
    apply(5'd14, 32'h0000_0003, 32'hFFFF_FFE5, 5'd0, 1'b1);
    apply(5'd16, 32'hF000_0000, 32'h0000_0024, 5'd1, 1'b1);
    // R10 unassigned codes.
    apply(5'd17, 32'h7FFF_FFFF, 32'h0000_0001, 5'd3, 1'b1);
    apply(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      op = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(17, 31))
                                       : 5'($urandom_range(0, 16));
      apply(op, pick_val(), pick_val(), 5'($urandom_range(0, 31)),
            ($urandom_range(0, 3) != 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule